// File: doc/BRIEF.md
# Graphics Controller Host Register Port Front End

This block sits between a host I/O bus and a VGA-compatible display controller. It decodes byte reads and writes on 16-bit port addresses. It keeps the CRT-controller index and register file, a banking register, and small stored copies of the miscellaneous-output, sequencer, graphics and attribute registers whose bits steer it. From these it drives the control outputs that the memory path and the timing generator use: two bank base offsets for the CPU memory window, the chain flags, and a one-cycle pulse asking for a timing recalculation.

Bit 0 of the miscellaneous-output register picks where the CRT-controller block appears. When it is clear, any access whose address lies in 0x3B0–0x3BF or 0x3D0–0x3DF has its address XORed with 0x60 before decoding, so the colour and mono ranges trade places. Writes take effect on the clock edge at which `io_wr` is high. Read data is combinational and valid while `io_rd` is high. The strobes are plain one-cycle qualifiers: every access completes in its own cycle, there is no back-pressure, and only one of `io_wr` and `io_rd` may be high in a cycle.

Top module: `vga_hostio_regs`

## Requirements
- R1: After reset the misc-output byte (write 0x3C2, read 0x3CC) is 0x01. The bank register, both bank bases, the CRTC index, every CRTC register, the stored register copies, the chain flags and the retime pulse are all 0.
- R2: While misc-output bit 0 is 0, an address in 0x3B0–0x3BF or 0x3D0–0x3DF is XORed with 0x60 before decoding. While the bit is 1, addresses decode unchanged, so the CRTC ports sit at 0x3D4/0x3D5.
- R3: A write to 0x3CD stores all 8 bits, and a read of 0x3CD returns that byte unchanged.
- R4: Bank bits 7:6 pick the segment mode. In mode 0, the write base is bits 2:0 shifted left by 17 and the read base is bits 5:3 shifted left by 17. In mode 1 the same fields are shifted left by 16. In modes 2 and 3 both bases keep their values.
- R5: A bank write updates the bases only when CRTC register 0x23 bit 7 is 0 and graphics register 6 bit 3 is 0. Otherwise the byte is still stored and both bases hold.
- R6: A write to 0x3D4 stores data bits 5:0 as the CRTC index. A read of 0x3D4 returns the index, and 0x3D5 reads and writes the indexed register. The sequencer index (0x3C4, 3 bits) and the graphics index (0x3CE, 4 bits) read back. Registers 4 (at 0x3C5) and 5 and 6 (at 0x3CF) read back their stored bytes.
- R7: While CRTC register 0x11 bit 7 is 1, writes to CRTC registers 0 to 6 are ignored, and a write to register 7 changes only its bit 4.
- R8: A CRTC data write that changes the stored value of a register whose index lies outside 0x0E–0x10 raises `retime_pulse` for exactly the following cycle. A write that leaves the value unchanged raises no pulse.
- R9: A write to sequencer register 4 sets `chain2_wr_mode` to the inverse of data bit 2 and `chain4_mode` to data bit 3.
- R10: `hires_chain` equals attribute register 0x16 bit 4 AND graphics register 5 bit 6. It is re-evaluated on a write to either of them.
- R11: A read of an undecoded port returns 0xFF. A write to an undecoded port changes no stored state.
- R12: Port 0x3C0 alternates between index and data on successive writes, starting with index. The data write reaches only register 0x16, and 0x3C1 reads it back. A read of status port 0x3DA returns 0x00 and returns the alternation to the index phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host port address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address |
| wr_bank_base | output | 20 | Offset added to CPU writes in the memory window |
| rd_bank_base | output | 20 | Offset added to CPU reads in the memory window |
| chain2_wr_mode | output | 1 | Chain-by-2 write mode flag |
| chain4_mode | output | 1 | Chain-4 flag from the sequencer |
| hires_chain | output | 1 | High-resolution chained-pixel flag |
| retime_pulse | output | 1 | One-cycle request to recalculate display timing |

## Verification
The assertions take for granted that `io_wr` and `io_rd` are never high together, and that the address is held steady for the whole cycle of a strobe. Several properties compare a register with the write data seen on the previous edge, so they hold only if a write is a single clean cycle. The bench drives every access from a task that raises one strobe for exactly one cycle at the falling edge and then drops it, so both conditions always hold. Protection checks also assume that the CRTC index does not change in the same cycle as a data write, and this follows from the one-strobe rule.

// File: rtl/hio_pkg.sv
package hio_pkg;
  localparam logic [15:0] PORT_ATTR      = 16'h03C0;
  localparam logic [15:0] PORT_ATTR_RD   = 16'h03C1;
  localparam logic [15:0] PORT_MISC_WR   = 16'h03C2;
  localparam logic [15:0] PORT_SEQ_IDX   = 16'h03C4;
  localparam logic [15:0] PORT_SEQ_DAT   = 16'h03C5;
  localparam logic [15:0] PORT_MISC_RD   = 16'h03CC;
  localparam logic [15:0] PORT_BANK      = 16'h03CD;
  localparam logic [15:0] PORT_GR_IDX    = 16'h03CE;
  localparam logic [15:0] PORT_GR_DAT    = 16'h03CF;
  localparam logic [15:0] PORT_CRTC_IDX  = 16'h03D4;
  localparam logic [15:0] PORT_CRTC_DAT  = 16'h03D5;
  localparam logic [15:0] PORT_STATUS    = 16'h03DA;

  // bit positions that neighbouring logic decodes
  localparam int BIT_MAP_COLOR  = 0;  // misc output
  localparam int BIT_PROTECT    = 7;  // crtc 0x11
  localparam int BIT_BANK_LOCK  = 7;  // crtc 0x23
  localparam int BIT_GR6_LOCK   = 3;  // graphics 6
  localparam int BIT_GR5_HIRES  = 6;  // graphics 5
  localparam int BIT_ATTR_HIRES = 4;  // attribute 0x16
  localparam int BIT_CH2_N      = 2;  // sequencer 4
  localparam int BIT_CH4        = 3;  // sequencer 4

  typedef enum logic [1:0] {
    SEG_128K = 2'd0,
    SEG_64K  = 2'd1,
    SEG_HOLD2 = 2'd2,
    SEG_HOLD3 = 2'd3
  } seg_mode_e;
endpackage

// File: rtl/hio_addr_remap.sv
module hio_addr_remap #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              map_color,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] COLOR_BLK = ADDR_W'('h3D0);
  localparam logic [ADDR_W-1:0] MONO_BLK  = ADDR_W'('h3B0);
  localparam logic [ADDR_W-1:0] SWAP_MASK = ADDR_W'('h060);

  logic in_swap_range;

  always_comb begin
    in_swap_range = (addr_in[ADDR_W-1:4] == COLOR_BLK[ADDR_W-1:4]) ||
                    (addr_in[ADDR_W-1:4] == MONO_BLK[ADDR_W-1:4]);
    addr_out = (!map_color && in_swap_range) ? (addr_in ^ SWAP_MASK) : addr_in;
  end
endmodule

// File: rtl/hio_crtc_file.sv
module hio_crtc_file #(
  parameter int DW        = 8,
  parameter int IDX_W     = 6,
  parameter int PROT_REG  = 'h11,
  parameter int PROT_LAST = 7,
  parameter int LOCK_REG  = 'h23,
  parameter int QUIET_LO  = 'h0E,
  parameter int QUIET_HI  = 'h10,
  parameter int KEEP_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             dat_wr,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic [DW-1:0]    sel_data,
  output logic             bank_lock,
  output logic             retime_pulse
);
  import hio_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_PROT  = IDX_W'(PROT_REG);
  localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(PROT_LAST);
  localparam logic [IDX_W-1:0] I_LOCK  = IDX_W'(LOCK_REG);
  localparam logic [IDX_W-1:0] I_QLO   = IDX_W'(QUIET_LO);
  localparam logic [IDX_W-1:0] I_QHI   = IDX_W'(QUIET_HI);
  localparam logic [DW-1:0]    KEEP_M  = DW'(1) << KEEP_BIT;

  logic [DW-1:0] regs [DEPTH];
  logic          protect;
  logic          allow;
  logic          quiet;
  logic [DW-1:0] next_val;

  assign sel_data  = regs[idx_q];
  assign protect   = regs[I_PROT][BIT_PROTECT];
  assign bank_lock = regs[I_LOCK][BIT_BANK_LOCK];

  always_comb begin
    allow    = 1'b1;
    next_val = wdata;
    if (protect && idx_q < I_LAST) begin
      allow = 1'b0;
    end else if (protect && idx_q == I_LAST) begin
      next_val = (regs[idx_q] & ~KEEP_M) | (wdata & KEEP_M);
    end
    quiet = (idx_q >= I_QLO) && (idx_q <= I_QHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      retime_pulse <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      retime_pulse <= dat_wr && allow && !quiet && (next_val != regs[idx_q]);
      if (idx_wr) idx_q <= wdata[IDX_W-1:0];
      if (dat_wr && allow) regs[idx_q] <= next_val;
    end
  end

  // R7: protected low registers keep their value
  p_protect_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_wr && protect && idx_q < I_LAST) |=> (sel_data == $past(sel_data)));

  // R7: protected register 7 changes only in the kept bit
  p_protect_r7_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_wr && protect && idx_q == I_LAST) |=>
      ((sel_data & ~KEEP_M) == ($past(sel_data) & ~KEEP_M)));

  // R8: a pulse always follows a data write
  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retime_pulse |-> $past(dat_wr));
endmodule

// File: rtl/hio_bank_unit.sv
module hio_bank_unit #(
  parameter int DW      = 8,
  parameter int FIELD_W = 3,
  parameter int SH_BIG  = 17,
  parameter int SH_SML  = 16,
  parameter int BASE_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              lock,
  output logic [DW-1:0]     bank_q,
  output logic [BASE_W-1:0] wr_base,
  output logic [BASE_W-1:0] rd_base
);
  import hio_pkg::*;
  localparam int MODE_LSB = 2 * FIELD_W;

  seg_mode_e         mode;
  logic [BASE_W-1:0] wf;
  logic [BASE_W-1:0] rf;

  assign mode = seg_mode_e'(wdata[MODE_LSB +: 2]);
  assign wf   = BASE_W'(wdata[FIELD_W-1:0]);
  assign rf   = BASE_W'(wdata[FIELD_W +: FIELD_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      wr_base <= '0;
      rd_base <= '0;
    end else if (wr) begin
      bank_q <= wdata;
      if (!lock) begin
        case (mode)
          SEG_128K: begin
            wr_base <= wf << SH_BIG;
            rd_base <= rf << SH_BIG;
          end
          SEG_64K: begin
            wr_base <= wf << SH_SML;
            rd_base <= rf << SH_SML;
          end
          default: ;
        endcase
      end
    end
  end

  p_byte_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (bank_q == $past(wdata)));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[MODE_LSB+1]) |=> ($stable(wr_base) && $stable(rd_base)));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock) |=> ($stable(wr_base) && $stable(rd_base)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(wr_base) && $stable(rd_base) && $stable(bank_q)));
endmodule

// File: rtl/vga_hostio_regs.sv
module vga_hostio_regs #(
  parameter int ADDR_W = 16,
  parameter int DW     = 8,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic [BASE_W-1:0] wr_bank_base,
  output logic [BASE_W-1:0] rd_bank_base,
  output logic              chain2_wr_mode,
  output logic              chain4_mode,
  output logic              hires_chain,
  output logic              retime_pulse
);
  import hio_pkg::*;
  localparam int CRTC_IDX_W = 6;
  localparam int SEQ_IDX_W  = 3;
  localparam int GR_IDX_W   = 4;
  localparam int ATTR_IDX_W = 5;
  localparam logic [DW-1:0] MISC_RST  = DW'(1);
  localparam logic [DW-1:0] NO_PORT   = '1;
  localparam logic [DW-1:0] STAT_VAL  = '0;
  localparam logic [SEQ_IDX_W-1:0]  SEQ_MEM  = SEQ_IDX_W'(4);
  localparam logic [GR_IDX_W-1:0]   GR_MODE  = GR_IDX_W'(5);
  localparam logic [GR_IDX_W-1:0]   GR_MISC  = GR_IDX_W'(6);
  localparam logic [ATTR_IDX_W-1:0] ATTR_HR  = ATTR_IDX_W'('h16);

  logic [ADDR_W-1:0]     addr_m;
  logic [DW-1:0]         misc_q;
  logic [SEQ_IDX_W-1:0]  seq_idx_q;
  logic [DW-1:0]         seq4_q;
  logic [GR_IDX_W-1:0]   gr_idx_q;
  logic [DW-1:0]         gr5_q;
  logic [DW-1:0]         gr6_q;
  logic                  attr_data_phase;
  logic [ATTR_IDX_W-1:0] attr_idx_q;
  logic [DW-1:0]         attr16_q;
  logic [CRTC_IDX_W-1:0] crtc_idx;
  logic [DW-1:0]         crtc_sel;
  logic                  crtc_lock;
  logic [DW-1:0]         bank_q;

  logic we_misc, we_seq_i, we_seq4, we_gr_i, we_gr5, we_gr6;
  logic we_bank, we_crtc_i, we_crtc_d, we_attr, we_attr16, rd_status;

  hio_addr_remap #(.ADDR_W(ADDR_W)) u_remap (
    .addr_in  (io_addr),
    .map_color(misc_q[BIT_MAP_COLOR]),
    .addr_out (addr_m)
  );

  always_comb begin
    we_misc   = io_wr && addr_m == ADDR_W'(PORT_MISC_WR);
    we_seq_i  = io_wr && addr_m == ADDR_W'(PORT_SEQ_IDX);
    we_seq4   = io_wr && addr_m == ADDR_W'(PORT_SEQ_DAT) && seq_idx_q == SEQ_MEM;
    we_gr_i   = io_wr && addr_m == ADDR_W'(PORT_GR_IDX);
    we_gr5    = io_wr && addr_m == ADDR_W'(PORT_GR_DAT) && gr_idx_q == GR_MODE;
    we_gr6    = io_wr && addr_m == ADDR_W'(PORT_GR_DAT) && gr_idx_q == GR_MISC;
    we_bank   = io_wr && addr_m == ADDR_W'(PORT_BANK);
    we_crtc_i = io_wr && addr_m == ADDR_W'(PORT_CRTC_IDX);
    we_crtc_d = io_wr && addr_m == ADDR_W'(PORT_CRTC_DAT);
    we_attr   = io_wr && addr_m == ADDR_W'(PORT_ATTR);
    we_attr16 = we_attr && attr_data_phase && attr_idx_q == ATTR_HR;
    rd_status = io_rd && addr_m == ADDR_W'(PORT_STATUS);
  end

  hio_crtc_file #(.DW(DW), .IDX_W(CRTC_IDX_W)) u_crtc (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_wr      (we_crtc_i),
    .dat_wr      (we_crtc_d),
    .wdata       (io_wdata),
    .idx_q       (crtc_idx),
    .sel_data    (crtc_sel),
    .bank_lock   (crtc_lock),
    .retime_pulse(retime_pulse)
  );

  hio_bank_unit #(.DW(DW), .BASE_W(BASE_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (we_bank),
    .wdata  (io_wdata),
    .lock   (crtc_lock || gr6_q[BIT_GR6_LOCK]),
    .bank_q (bank_q),
    .wr_base(wr_bank_base),
    .rd_base(rd_bank_base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q          <= MISC_RST;
      seq_idx_q       <= '0;
      seq4_q          <= '0;
      gr_idx_q        <= '0;
      gr5_q           <= '0;
      gr6_q           <= '0;
      attr_data_phase <= 1'b0;
      attr_idx_q      <= '0;
      attr16_q        <= '0;
      chain2_wr_mode  <= 1'b0;
      chain4_mode     <= 1'b0;
      hires_chain     <= 1'b0;
    end else begin
      if (we_misc)  misc_q    <= io_wdata;
      if (we_seq_i) seq_idx_q <= io_wdata[SEQ_IDX_W-1:0];
      if (we_gr_i)  gr_idx_q  <= io_wdata[GR_IDX_W-1:0];
      if (we_gr6)   gr6_q     <= io_wdata;
      if (we_seq4) begin
        seq4_q         <= io_wdata;
        chain2_wr_mode <= ~io_wdata[BIT_CH2_N];
        chain4_mode    <= io_wdata[BIT_CH4];
      end
      if (we_gr5) begin
        gr5_q       <= io_wdata;
        hires_chain <= io_wdata[BIT_GR5_HIRES] & attr16_q[BIT_ATTR_HIRES];
      end
      if (we_attr16) begin
        attr16_q    <= io_wdata;
        hires_chain <= io_wdata[BIT_ATTR_HIRES] & gr5_q[BIT_GR5_HIRES];
      end
      if (rd_status) begin
        attr_data_phase <= 1'b0;
      end else if (we_attr) begin
        if (!attr_data_phase) attr_idx_q <= io_wdata[ATTR_IDX_W-1:0];
        attr_data_phase <= ~attr_data_phase;
      end
    end
  end

  always_comb begin
    io_rdata = NO_PORT;
    case (addr_m)
      ADDR_W'(PORT_ATTR):     io_rdata = DW'(attr_idx_q);
      ADDR_W'(PORT_ATTR_RD):  io_rdata = (attr_idx_q == ATTR_HR) ? attr16_q : NO_PORT;
      ADDR_W'(PORT_MISC_RD):  io_rdata = misc_q;
      ADDR_W'(PORT_SEQ_IDX):  io_rdata = DW'(seq_idx_q);
      ADDR_W'(PORT_SEQ_DAT):  io_rdata = (seq_idx_q == SEQ_MEM) ? seq4_q : NO_PORT;
      ADDR_W'(PORT_BANK):     io_rdata = bank_q;
      ADDR_W'(PORT_GR_IDX):   io_rdata = DW'(gr_idx_q);
      ADDR_W'(PORT_GR_DAT):   io_rdata = (gr_idx_q == GR_MODE) ? gr5_q :
                                         (gr_idx_q == GR_MISC) ? gr6_q : NO_PORT;
      ADDR_W'(PORT_CRTC_IDX): io_rdata = DW'(crtc_idx);
      ADDR_W'(PORT_CRTC_DAT): io_rdata = crtc_sel;
      ADDR_W'(PORT_STATUS):   io_rdata = STAT_VAL;
      default:                io_rdata = NO_PORT;
    endcase
  end

  p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_seq4 |=> ((chain2_wr_mode == ~$past(io_wdata[BIT_CH2_N])) &&
                 (chain4_mode == $past(io_wdata[BIT_CH4]))));

  p_hires_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hires_chain |-> (gr5_q[BIT_GR5_HIRES] && attr16_q[BIT_ATTR_HIRES]));

  p_status_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> !attr_data_phase);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_rd));
endmodule

// File: tb/sim_vga_hostio_regs.sv
module sim_vga_hostio_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] wr_bank_base;
  logic [19:0] rd_bank_base;
  logic        chain2_wr_mode;
  logic        chain4_mode;
  logic        hires_chain;
  logic        retime_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_hostio_regs u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .wr_bank_base(wr_bank_base),
    .rd_bank_base(rd_bank_base), .chain2_wr_mode(chain2_wr_mode),
    .chain4_mode(chain4_mode), .hires_chain(hires_chain), .retime_pulse(retime_pulse)
  );

  // {write, requirement number, address, data, expected read}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 4'd1,  16'h03CC, 8'h00, 8'h01},  // R1 misc reset
    {1'b0, 4'd1,  16'h03CD, 8'h00, 8'h00},  // R1 bank reset
    {1'b0, 4'd1,  16'h03D5, 8'h00, 8'h00},  // R1 crtc reset
    {1'b1, 4'd6,  16'h03D4, 8'hC7, 8'h00},  // R6 index masked
    {1'b0, 4'd6,  16'h03D4, 8'h00, 8'h07},
    {1'b1, 4'd6,  16'h03D5, 8'h5A, 8'h00},
    {1'b0, 4'd6,  16'h03D5, 8'h00, 8'h5A},
    {1'b0, 4'd11, 16'h03B4, 8'h00, 8'hFF},  // R11 mono port unmapped
    {1'b1, 4'd3,  16'h03CD, 8'hAB, 8'h00},  // R3
    {1'b0, 4'd3,  16'h03CD, 8'h00, 8'hAB},
    {1'b1, 4'd2,  16'h03C2, 8'h00, 8'h00},  // R2 swap ranges
    {1'b0, 4'd2,  16'h03CC, 8'h00, 8'h00},
    {1'b0, 4'd2,  16'h03B4, 8'h00, 8'h07},
    {1'b0, 4'd2,  16'h03D4, 8'h00, 8'hFF},
    {1'b1, 4'd7,  16'h03B4, 8'h11, 8'h00},  // R7 protect on
    {1'b1, 4'd7,  16'h03B5, 8'h80, 8'h00},
    {1'b1, 4'd7,  16'h03B4, 8'h03, 8'h00},
    {1'b1, 4'd7,  16'h03B5, 8'h44, 8'h00},
    {1'b0, 4'd7,  16'h03B5, 8'h00, 8'h00},
    {1'b1, 4'd7,  16'h03B4, 8'h07, 8'h00},
    {1'b1, 4'd7,  16'h03B5, 8'h00, 8'h00},
    {1'b0, 4'd7,  16'h03B5, 8'h00, 8'h4A},
    {1'b1, 4'd7,  16'h03B5, 8'hFF, 8'h00},
    {1'b0, 4'd7,  16'h03B5, 8'h00, 8'h5A},
    {1'b1, 4'd2,  16'h03C2, 8'h01, 8'h00},
    {1'b1, 4'd11, 16'h0300, 8'h55, 8'h00},  // R11 undecoded
    {1'b0, 4'd11, 16'h0300, 8'h00, 8'hFF},
    {1'b1, 4'd9,  16'h03C4, 8'h04, 8'h00},  // R9
    {1'b1, 4'd9,  16'h03C5, 8'h0C, 8'h00},
    {1'b0, 4'd9,  16'h03C5, 8'h00, 8'h0C},
    {1'b0, 4'd9,  16'h03C4, 8'h00, 8'h04},
    {1'b1, 4'd10, 16'h03CE, 8'h05, 8'h00},  // R10
    {1'b1, 4'd10, 16'h03CF, 8'h40, 8'h00},
    {1'b0, 4'd10, 16'h03CF, 8'h00, 8'h40},
    {1'b1, 4'd6,  16'h03D4, 8'h11, 8'h00},
    {1'b1, 4'd6,  16'h03D5, 8'h00, 8'h00},
    {1'b0, 4'd6,  16'h03D5, 8'h00, 8'h00},
    {1'b0, 4'd12, 16'h03DA, 8'h00, 8'h00},  // R12 status
    {1'b0, 4'd11, 16'h03CD, 8'h00, 8'hAB},
    {1'b0, 4'd11, 16'h03CC, 8'h00, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(io_rdata === exp, req, 32'(io_rdata), 32'(exp));
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bases(input logic [19:0] ew, input logic [19:0] er, input string req);
    chk(wr_bank_base === ew, req, 32'(wr_bank_base), 32'(ew));
    chk(rd_bank_base === er, req, 32'(rd_bank_base), 32'(er));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) wr(VEC[i][31:16], VEC[i][15:8]);
      else rd(VEC[i][31:16], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][35:32], i));
    end

    // R1: reset state at the ports
    do_reset();
    #1;
    bases(20'h0, 20'h0, "R1 bases");
    chk({chain2_wr_mode, chain4_mode, hires_chain, retime_pulse} === 4'b0, "R1 flags",
        32'({chain2_wr_mode, chain4_mode, hires_chain, retime_pulse}), 0);

    // R4: segment modes
    wr(16'h03CD, 8'h1D); bases(20'hA0000, 20'h60000, "R4 mode0");
    wr(16'h03CD, 8'h5D); bases(20'h50000, 20'h30000, "R4 mode1");
    wr(16'h03CD, 8'hBF); bases(20'h50000, 20'h30000, "R4 mode2");
    wr(16'h03CD, 8'hC1); bases(20'h50000, 20'h30000, "R4 mode3");
    rd(16'h03CD, 8'hC1, "R3 mode3 byte");

    // R5: two lock sources
    wr(16'h03D4, 8'h23); wr(16'h03D5, 8'h80);
    wr(16'h03CD, 8'h09); bases(20'h50000, 20'h30000, "R5 crtc lock");
    rd(16'h03CD, 8'h09, "R5 byte stored");
    wr(16'h03D5, 8'h00);
    wr(16'h03CE, 8'h06); wr(16'h03CF, 8'h08);
    wr(16'h03CD, 8'h09); bases(20'h50000, 20'h30000, "R5 gr6 lock");
    wr(16'h03CF, 8'h00);
    wr(16'h03CD, 8'h09); bases(20'h20000, 20'h20000, "R5 unlocked");

    // R8: retime pulse
    wr(16'h03D4, 8'h0E); wr(16'h03D5, 8'h33);
    chk(retime_pulse === 1'b0, "R8 quiet 0E", 32'(retime_pulse), 0);
    wr(16'h03D4, 8'h10); wr(16'h03D5, 8'h01);
    chk(retime_pulse === 1'b0, "R8 quiet 10", 32'(retime_pulse), 0);
    wr(16'h03D4, 8'h0D); wr(16'h03D5, 8'h01);
    chk(retime_pulse === 1'b1, "R8 edge 0D", 32'(retime_pulse), 1);
    wr(16'h03D4, 8'h02); wr(16'h03D5, 8'h33);
    chk(retime_pulse === 1'b1, "R8 pulse", 32'(retime_pulse), 1);
    @(negedge clk);
    chk(retime_pulse === 1'b0, "R8 one cycle", 32'(retime_pulse), 0);
    wr(16'h03D5, 8'h33);
    chk(retime_pulse === 1'b0, "R8 same value", 32'(retime_pulse), 0);

    // R9: chain flags
    wr(16'h03C4, 8'h04); wr(16'h03C5, 8'h08);
    chk(chain2_wr_mode === 1'b1 && chain4_mode === 1'b1, "R9 set",
        32'({chain2_wr_mode, chain4_mode}), 32'h3);
    wr(16'h03C5, 8'h04);
    chk(chain2_wr_mode === 1'b0 && chain4_mode === 1'b0, "R9 clear",
        32'({chain2_wr_mode, chain4_mode}), 0);

    // R10 / R12: hires chain via attribute 0x16
    wr(16'h03CE, 8'h05); wr(16'h03CF, 8'h40);
    rd(16'h03DA, 8'h00, "R12 status");
    wr(16'h03C0, 8'h16); wr(16'h03C0, 8'h10);
    chk(hires_chain === 1'b1, "R10 attr write", 32'(hires_chain), 1);
    rd(16'h03C1, 8'h10, "R12 attr readback");
    wr(16'h03CF, 8'h00);
    chk(hires_chain === 1'b0, "R10 gr5 clear", 32'(hires_chain), 0);
    wr(16'h03CF, 8'h40);
    chk(hires_chain === 1'b1, "R10 gr5 reeval", 32'(hires_chain), 1);
    wr(16'h03C0, 8'h16);
    rd(16'h03DA, 8'h00, "R12 status reset");
    wr(16'h03C0, 8'h05); wr(16'h03C0, 8'h00);
    chk(hires_chain === 1'b1, "R12 other index", 32'(hires_chain), 1);
    rd(16'h03C0, 8'h05, "R12 index readback");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule